// File: doc/BRIEF.md
# Controller Interrupt Service and Stall Watchdog

This block works beside a storage-controller sequencer. It services the controller's interrupt line, tells the sequencer when to run again, and rescues the sequencer when an expected event never arrives. When the interrupt line is high and the block is idle, it reads the controller's control register. It then writes that value back with the interrupt-reset bit set, and writes the untouched value once more. Next it reads the status register. One cycle after that it raises a single wake pulse for the sequencer. The same pulse may carry a transfer-error flag, a spurious-interrupt flag, or both.

A stall watchdog runs in parallel. It is armed when the sequencer's busy signal rises. It is cancelled when the sequencer is idle and has nothing queued. Each time it expires it reloads itself and sends a forced wake, so a sequencer that stays stuck is kicked over and over. With the `POLLED` parameter set, the block behaves as if no interrupt line were fitted: the line is ignored, no acknowledge traffic is ever issued, and the wake output follows the sequencer's wait signal on every cycle. Once after reset, in both modes, the block writes a fixed start-up word into the control register.

States of the service machine: `SV_BOOT` (reset) → `SV_INIT` (start-up write) → `SV_IDLE`. From `SV_IDLE`, the interrupt moves it to `SV_GET_CTRL` → `SV_ACK_SET` → `SV_ACK_RESTORE` → `SV_GET_STAT` → `SV_NOTIFY` → back to `SV_IDLE`. Each bus state advances only on `reg_ack_i`. `SV_BOOT` and `SV_NOTIFY` advance unconditionally.

Top module: `ctlr_irq_guard`

## Requirements
- R1: After reset, and before any other access, the block issues exactly one write to the control address (`CTRL_ADDR`, default 0x18) with the word 0x0308. That word has bit 3 (force configuration mode), bit 8 (buffer-ready interrupt enable) and bit 9 (error interrupt enable) set. While reset is held, no request and no wake is issued.
- R2: With the interrupt line high in idle, the block makes four accesses in this order: a read of the control address; a write of the read value OR 0x0800 (bit 11 = interrupt reset); a write of the read value unchanged; a read of the status address (`STAT_ADDR`, default 0x04). `wake_o` is high for exactly the one cycle after the status read is acknowledged.
- R3: A bus request stays asserted, with address, direction and write data unchanged, until `reg_ack_i` is seen.
- R4: `xfer_err_o` is high together with the interrupt wake only when the status word read has bit 2 (configuration error) or bit 3 (card-controller error) set, and the control word read has bit 9 set.
- R5: If `task_active_i` is low in the wake cycle of a serviced interrupt, `spurious_o` is high in that cycle and the wake is still issued.
- R6: A rising edge of `seq_busy_i` arms the watchdog. If it is not cancelled, `kick_o` and `wake_o` rise for one cycle `TIMEOUT_CYC` cycles after the arming edge.
- R7: On expiry the watchdog reloads the full timeout, so a stall that persists gets a kick every `TIMEOUT_CYC` cycles.
- R8: While armed, the watchdog is cancelled (no further kicks) when `seq_busy_i` and `work_pend_i` are both low. It keeps counting while `work_pend_i` is high, even if `seq_busy_i` is low.
- R9: If a watchdog expiry falls in the same cycle as an interrupt wake, both are delivered in one cycle. `wake_o` and `kick_o` are high together, and the error and spurious flags still reflect the serviced interrupt.
- R10: With `POLLED` = 1, the block issues no bus request after the start-up write, whatever the interrupt line does. `wake_o` equals `seq_wait_i` OR `kick_o` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Controller interrupt line, level sensitive |
| seq_busy_i | input | 1 | Sequencer is out of its idle state |
| work_pend_i | input | 1 | Sequencer has queued work |
| task_active_i | input | 1 | Sequencer has an operation in progress |
| seq_wait_i | input | 1 | Sequencer is waiting for an event (polled mode) |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | Access is a write |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid with `reg_ack_i` |
| reg_ack_i | input | 1 | Access accepted this cycle |
| wake_o | output | 1 | Run the sequencer |
| kick_o | output | 1 | This wake comes from the watchdog |
| xfer_err_o | output | 1 | Qualified transfer error, with the wake |
| spurious_o | output | 1 | Interrupt arrived with no task active |

## Verification
Two functions can land on the same cycle: the interrupt wake that ends an acknowledge sequence, and the watchdog's forced wake. To make them meet, the bench raises `seq_busy_i`, waits `TIMEOUT_CYC`−4 cycles, and then asserts the interrupt. That timing makes the notify state and the expiry edge coincide. The cycle-by-cycle model predicts one combined wake with `kick_o` high in that cycle. The bench also counts how often `wake_o` and `kick_o` are seen high together, and judges this from that count and from the per-cycle comparison against the model.

// File: rtl/ctlr_irq_pkg.sv
package ctlr_irq_pkg;

    typedef enum logic [2:0] {
        SV_BOOT,
        SV_INIT,
        SV_IDLE,
        SV_GET_CTRL,
        SV_ACK_SET,
        SV_ACK_RESTORE,
        SV_GET_STAT,
        SV_NOTIFY
    } svc_state_e;

    // control register bit positions
    localparam int CTRL_FORCE_MODE_BIT = 3;
    localparam int CTRL_BUFRDY_IE_BIT  = 8;
    localparam int CTRL_ERR_IE_BIT     = 9;
    localparam int CTRL_IRQ_RST_BIT    = 11;

    // status register bit positions
    localparam int STAT_CFG_ERR_BIT    = 2;
    localparam int STAT_CARD_ERR_BIT   = 3;

endpackage

// File: rtl/ctlr_irq_svc.sv
module ctlr_irq_svc
    import ctlr_irq_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic              task_active,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              irq_wake,
    output logic              irq_err,
    output logic              irq_spur
);

    localparam logic [DATA_W-1:0] INIT_WORD =
        (DATA_W'(1) << CTRL_FORCE_MODE_BIT) |
        (DATA_W'(1) << CTRL_BUFRDY_IE_BIT)  |
        (DATA_W'(1) << CTRL_ERR_IE_BIT);
    localparam logic [DATA_W-1:0] IRQ_RST_MASK = DATA_W'(1) << CTRL_IRQ_RST_BIT;

    svc_state_e        state_q, state_d;
    logic [DATA_W-1:0] ctrl_q;
    logic              stat_err_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_BOOT:        state_d = SV_INIT;
            SV_INIT:        if (bus_ack) state_d = SV_IDLE;
            SV_IDLE:        if (irq)     state_d = SV_GET_CTRL;
            SV_GET_CTRL:    if (bus_ack) state_d = SV_ACK_SET;
            SV_ACK_SET:     if (bus_ack) state_d = SV_ACK_RESTORE;
            SV_ACK_RESTORE: if (bus_ack) state_d = SV_GET_STAT;
            SV_GET_STAT:    if (bus_ack) state_d = SV_NOTIFY;
            SV_NOTIFY:      state_d = SV_IDLE;
            default:        state_d = SV_IDLE;
        endcase
    end

    // state register and captured words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SV_BOOT;
            ctrl_q     <= '0;
            stat_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SV_GET_CTRL && bus_ack) begin
                ctrl_q <= bus_rdata;
            end
            if (state_q == SV_GET_STAT && bus_ack) begin
                stat_err_q <= bus_rdata[STAT_CFG_ERR_BIT] | bus_rdata[STAT_CARD_ERR_BIT];
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = CTRL_ADDR;
        bus_wdata = '0;
        irq_wake  = 1'b0;
        irq_err   = 1'b0;
        irq_spur  = 1'b0;
        unique case (state_q)
            SV_BOOT, SV_IDLE: begin
            end
            SV_INIT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = INIT_WORD;
            end
            SV_GET_CTRL: begin
                bus_req = 1'b1;
            end
            SV_ACK_SET: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = ctrl_q | IRQ_RST_MASK;
            end
            SV_ACK_RESTORE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = ctrl_q;
            end
            SV_GET_STAT: begin
                bus_req  = 1'b1;
                bus_addr = STAT_ADDR;
            end
            SV_NOTIFY: begin
                irq_wake = 1'b1;
                irq_err  = stat_err_q & ctrl_q[CTRL_ERR_IE_BIT];
                irq_spur = ~task_active;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ctlr_stall_wdog.sv
module ctlr_stall_wdog #(
    parameter int TIMEOUT_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic pend,
    output logic fire
);

    localparam int               CNT_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYC - 1);

    logic             busy_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fire_q  <= 1'b0;
        end else begin
            busy_q <= busy;
            fire_q <= 1'b0;
            if (busy && !busy_q) begin
                armed_q <= 1'b1;
                cnt_q   <= RELOAD;
            end else if (armed_q && !busy && !pend) begin
                armed_q <= 1'b0;
            end else if (armed_q) begin
                if (cnt_q == '0) begin
                    fire_q <= 1'b1;
                    cnt_q  <= RELOAD;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign fire = fire_q;

endmodule

// File: rtl/ctlr_irq_guard.sv
module ctlr_irq_guard #(
    parameter int                DATA_W      = 16,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h18,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h04,
    parameter int                TIMEOUT_CYC = 50_000_000,
    parameter bit                POLLED      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_i,
    input  logic              seq_busy_i,
    input  logic              work_pend_i,
    input  logic              task_active_i,
    input  logic              seq_wait_i,
    output logic              reg_req_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_ack_i,
    output logic              wake_o,
    output logic              kick_o,
    output logic              xfer_err_o,
    output logic              spurious_o
);

    logic svc_irq;
    logic svc_wake;
    logic wd_fire;

    ctlr_irq_svc #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq        (svc_irq),
        .task_active(task_active_i),
        .bus_req    (reg_req_o),
        .bus_we     (reg_we_o),
        .bus_addr   (reg_addr_o),
        .bus_wdata  (reg_wdata_o),
        .bus_rdata  (reg_rdata_i),
        .bus_ack    (reg_ack_i),
        .irq_wake   (svc_wake),
        .irq_err    (xfer_err_o),
        .irq_spur   (spurious_o)
    );

    ctlr_stall_wdog #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_wdog (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (seq_busy_i),
        .pend (work_pend_i),
        .fire (wd_fire)
    );

    generate
        if (POLLED) begin : g_polled
            assign svc_irq = 1'b0;
            assign wake_o  = seq_wait_i | wd_fire;
        end else begin : g_irq
            assign svc_irq = irq_i;
            assign wake_o  = svc_wake | wd_fire;
        end
    endgenerate

    assign kick_o = wd_fire;

endmodule

// File: rtl/ctlr_irq_guard_chk.sv
module ctlr_irq_guard_chk #(
    parameter int                DATA_W      = 16,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h18,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h04,
    parameter int                TIMEOUT_CYC = 50_000_000,
    parameter bit                POLLED      = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_i,
    input logic              seq_busy_i,
    input logic              work_pend_i,
    input logic              task_active_i,
    input logic              seq_wait_i,
    input logic              reg_req_o,
    input logic              reg_we_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [DATA_W-1:0] reg_wdata_o,
    input logic [DATA_W-1:0] reg_rdata_i,
    input logic              reg_ack_i,
    input logic              wake_o,
    input logic              kick_o,
    input logic              xfer_err_o,
    input logic              spurious_o
);

    localparam logic [DATA_W-1:0] START_WORD = DATA_W'(16'h0308);

    logic init_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_seen <= 1'b0;
        end else if (reg_req_o && reg_ack_i && reg_we_o) begin
            init_seen <= 1'b1;
        end
    end

    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_seen && reg_req_o) |-> (reg_we_o && reg_addr_o == CTRL_ADDR && reg_wdata_o == START_WORD)); // R1

    AST_WAKE_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!POLLED && reg_req_o && reg_ack_i && !reg_we_o && reg_addr_o == STAT_ADDR) |=> wake_o); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o) && $stable(reg_wdata_o))); // R3

    AST_ERR_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err_o |-> wake_o); // R4

    AST_SPUR_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        spurious_o |-> wake_o); // R5

    AST_KICK_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> wake_o); // R6

    AST_KICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (TIMEOUT_CYC > 1 && kick_o) |=> !kick_o); // R7

    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (POLLED && init_seen) |-> !reg_req_o); // R10

endmodule

bind ctlr_irq_guard ctlr_irq_guard_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .STAT_ADDR  (STAT_ADDR),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .POLLED     (POLLED)
) u_chk (.*);

// File: tb/test_ctlr_irq_guard.sv
`timescale 1ns/1ps
module test_ctlr_irq_guard;

    localparam int          CLK_PERIOD = 10;
    localparam int          T          = 20;
    localparam logic [7:0]  A_CTRL     = 8'h18;
    localparam logic [7:0]  A_STAT     = 8'h04;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_i = 1'b0, busy = 1'b0, pend = 1'b0, task_active = 1'b1, seq_wait = 1'b0;
    logic ack_en = 1'b1;
    logic [15:0] dev_stat = 16'h0000;
    logic [15:0] dev_ctrl;
    logic        ovr_en = 1'b0;
    logic [15:0] ovr_val = 16'h0000;

    logic        req, we, ack, wake, kick, err, spur;
    logic [7:0]  addr;
    logic [15:0] wdata, rdata;
    logic        p_req, p_we, p_wake, p_kick, p_err, p_spur;
    logic [7:0]  p_addr;
    logic [15:0] p_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ack   = req & ack_en;
    assign rdata = (addr == A_CTRL) ? dev_ctrl : dev_stat;

    always @(posedge clk) begin
        if (!rst_n)                              dev_ctrl <= 16'h0000;
        else if (ovr_en)                         dev_ctrl <= ovr_val;
        else if (ack && we && addr == A_CTRL)    dev_ctrl <= wdata;
    end

    ctlr_irq_guard #(.TIMEOUT_CYC(T), .POLLED(1'b0)) i_ctlr_irq_guard (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .seq_busy_i(busy), .work_pend_i(pend),
        .task_active_i(task_active), .seq_wait_i(seq_wait),
        .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
        .reg_rdata_i(rdata), .reg_ack_i(ack),
        .wake_o(wake), .kick_o(kick), .xfer_err_o(err), .spurious_o(spur));

    ctlr_irq_guard #(.TIMEOUT_CYC(T), .POLLED(1'b1)) i_ctlr_irq_guard_poll (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .seq_busy_i(busy), .work_pend_i(pend),
        .task_active_i(task_active), .seq_wait_i(seq_wait),
        .reg_req_o(p_req), .reg_we_o(p_we), .reg_addr_o(p_addr), .reg_wdata_o(p_wdata),
        .reg_rdata_i(16'h0000), .reg_ack_i(p_req),
        .wake_o(p_wake), .kick_o(p_kick), .xfer_err_o(p_err), .spurious_o(p_spur));

    int n_tests = 0;
    int n_fail  = 0;
    int kicks_win = 0;
    int coincide = 0;
    int poll_bus_late = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 7 boot, 0 start-up write, 1 idle,
    // 2 read ctrl, 3 set write, 4 restore write, 5 read status, 6 wake
    int          ph, pph;
    logic [15:0] m_ctrl;
    bit          m_se;
    bit          armed, bprev, exp_kick;
    int          age;

    function automatic bit ph_req(int p);
        return (p >= 0 && p <= 5 && p != 1);
    endfunction

    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst_n) begin
            chk(!req && !wake && !kick, "R1", "outputs in reset", {req, wake, kick}, 0);
            chk(!p_req && !p_wake, "R1", "poll outputs in reset", {p_req, p_wake}, 0);
            ph = 7; pph = 7; m_ctrl = '0; m_se = 0;
            armed = 0; bprev = 0; exp_kick = 0; age = 0;
        end else begin : cmp
            string rq;
            bit    e_req, e_we, e_wake;
            logic [7:0]  e_addr;
            logic [15:0] e_wd;
            e_req = ph_req(ph);
            e_we = (ph == 0 || ph == 3 || ph == 4);
            e_addr = (ph == 5) ? A_STAT : A_CTRL;
            e_wd = (ph == 0) ? 16'h0308 : (ph == 3) ? (m_ctrl | 16'h0800) : m_ctrl;
            rq = (ph == 0) ? "R1" : (!ack_en ? "R3" : "R2");
            chk(req == e_req, rq, "reg_req_o", req, e_req);
            if (e_req) begin
                chk(we == e_we && addr == e_addr, rq, "we/addr", {we, addr}, {e_we, e_addr});
                if (e_we) chk(wdata == e_wd, rq, "reg_wdata_o", wdata, e_wd);
            end
            e_wake = (ph == 6) || exp_kick;
            chk(wake == e_wake, (ph == 6) ? "R2" : "R6", "wake_o", wake, e_wake);
            chk(kick == exp_kick, "R6", "kick_o", kick, exp_kick);
            chk(err == ((ph == 6) && m_se && m_ctrl[9]), "R4", "xfer_err_o", err, (ph == 6) && m_se && m_ctrl[9]);
            chk(spur == ((ph == 6) && !task_active), "R5", "spurious_o", spur, (ph == 6) && !task_active);
            // polled instance
            chk(p_req == (pph == 0), "R10", "poll reg_req_o", p_req, pph == 0);
            if (pph == 0) chk(p_we && p_wdata == 16'h0308, "R1", "poll start word", p_wdata, 16'h0308);
            chk(p_wake == (seq_wait || exp_kick), "R10", "poll wake_o", p_wake, seq_wait || exp_kick);
            chk(!p_err && !p_spur, "R10", "poll flags", {p_err, p_spur}, 0);
            if (pph == 1 && p_req) poll_bus_late++;
            if (kick) kicks_win++;
            if (wake && kick && ph == 6) coincide++;
            // step reference to the state after the coming edge
            case (ph)
                7: ph = 0;
                0: if (ack_en) ph = 1;
                1: if (irq_i) ph = 2;
                2: if (ack_en) begin m_ctrl = dev_ctrl; ph = 3; end
                3: if (ack_en) ph = 4;
                4: if (ack_en) ph = 5;
                5: if (ack_en) begin m_se = dev_stat[2] | dev_stat[3]; ph = 6; end
                6: ph = 1;
                default: ph = 1;
            endcase
            case (pph)
                7: pph = 0;
                0: pph = 1;
                default: pph = 1;
            endcase
            exp_kick = 0;
            if (busy && !bprev) begin armed = 1; age = 0; end
            else if (armed && !busy && !pend) armed = 0;
            else if (armed) begin
                age++;
                if (age == T) begin exp_kick = 1; age = 0; end
            end
            bprev = busy;
        end
    end

    task automatic service();
        irq_i = 1'b1;
        do @(negedge clk);
        while (!(req && we && addr == A_CTRL && wdata[11] && ack_en));
        irq_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired: run hung");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);                      // R1 start-up write

        service();                                      // R2 plain acknowledge

        ack_en = 1'b0; irq_i = 1'b1;                    // R3 stalled bus
        repeat (3) @(negedge clk);
        ack_en = 1'b1;
        do @(negedge clk); while (!(req && we && wdata[11]));
        irq_i = 1'b0;
        @(negedge clk);
        ack_en = 1'b0;
        repeat (2) @(negedge clk);
        ack_en = 1'b1;
        repeat (5) @(negedge clk);

        dev_stat = 16'h0004; service();                 // R4 config error
        dev_stat = 16'h0008; service();                 // R4 card error
        ovr_val = 16'h0108; ovr_en = 1'b1; @(negedge clk); ovr_en = 1'b0;
        dev_stat = 16'h000C; service();                 // R4 not qualified
        ovr_val = 16'h0308; ovr_en = 1'b1; @(negedge clk); ovr_en = 1'b0;
        dev_stat = 16'h0000;

        task_active = 1'b0; service(); task_active = 1'b1;   // R5

        busy = 1'b1; kicks_win = 0;                     // R6, R7
        repeat (2*T + T/2) @(negedge clk);
        chk(kicks_win == 2, "R7", "kicks while stalled", kicks_win, 2);
        pend = 1'b1; busy = 1'b0; kicks_win = 0;        // R8 pending keeps it armed
        repeat (T + T/4) @(negedge clk);
        chk(kicks_win == 1, "R8", "kicks with work pending", kicks_win, 1);
        pend = 1'b0; kicks_win = 0;                     // R8 cancel
        repeat (3*T) @(negedge clk);
        chk(kicks_win == 0, "R8", "kicks after cancel", kicks_win, 0);

        busy = 1'b1; task_active = 1'b0; dev_stat = 16'h0004;   // R9 coincidence
        repeat (T - 4) @(negedge clk);
        service();
        chk(coincide == 1, "R9", "joint wake and kick", coincide, 1);
        busy = 1'b0; task_active = 1'b1; dev_stat = 16'h0000;
        repeat (4) @(negedge clk);

        for (int i = 0; i < 12; i++) begin              // R10 polled wake
            seq_wait = i[0] ^ i[2];
            @(negedge clk);
        end
        seq_wait = 1'b1;
        service();
        seq_wait = 1'b0;
        repeat (3) @(negedge clk);
        chk(poll_bus_late == 0, "R10", "poll bus after start-up", poll_bus_late, 0);
        summary();
    end

endmodule